// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a 20-bit physical byte address. It keeps four segment registers: code, data, stack and extra. Each access has a kind, and the kind picks which register supplies the base. The base is the segment value moved up four bit positions, so every segment starts on a 16-byte boundary and covers 64 KB. The adder drops any carry out of bit 19, so addresses wrap within the 1 MB space.

Some access kinds may replace their default segment with one named by an override request. Others may not. An override requested on a kind that forbids it has no effect on the address, and a fault pulse is raised for that access. The block treats every clock cycle as one access. The address and the fault flag are registered and appear one cycle after the inputs. A segment register written in a cycle serves accesses from the next cycle onward.

Top module: `seg_addr_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `phys_addr` is 0 and `ovr_fault` is 0. Every segment register resets to 0000h.
- R2: The result for an access appears on `phys_addr` at the clock edge after the access is presented. The result is (segment << 4) + zero-extended offset, for example 1234h:0022h gives 12362h.
- R3: The sum keeps only its low 20 bits, for example FFFFh:0010h gives 00000h and FFFFh:FFFFh gives 0FFEFh.
- R4: Access kind 0 (instruction fetch) always uses the code segment.
- R5: Access kind 1 (stack) always uses the stack segment.
- R6: Access kind 2 (general data) uses the data segment. When `ovr_req` is 1 it uses the segment coded on `ovr_seg` instead: 0 code, 1 data, 2 stack, 3 extra.
- R7: Access kind 3 (string source) defaults to the data segment and obeys overrides in the same way as kind 2.
- R8: Access kind 4 (string destination) always uses the extra segment.
- R9: Access kinds 5, 6 and 7 behave as general data (kind 2).
- R10: When `seg_we` is 1, `seg_wdata` is loaded into the register coded on `seg_wsel` (same codes as `ovr_seg`). An access presented in the same cycle sees the old value. The next access sees the new value.
- R11: For access kinds 0, 1 and 4, an override request has no effect on `phys_addr`. It sets `ovr_fault` to 1 for exactly that access's result cycle.
- R12: `ovr_fault` is 0 for any access without an override request, and for any override on kinds 2, 3, 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_kind | input | 3 | Access kind of this cycle's access |
| acc_off | input | 16 | Offset within the segment |
| ovr_req | input | 1 | Request to use `ovr_seg` instead of the default segment |
| ovr_seg | input | 2 | Requested segment: 0 code, 1 data, 2 stack, 3 extra |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 2 | Segment register to write, same codes as `ovr_seg` |
| seg_wdata | input | 16 | Value to write |
| phys_addr | output | 20 | Registered physical address |
| ovr_fault | output | 1 | Registered pulse: override refused for this access |

## Verification
The properties assume that every clock cycle carries a valid access, and that the inputs settle well before each rising edge. The checker keeps its own copy of the segment registers, built only from the write port. This copy is valid only if no write happens while reset is high.

The stimulus changes inputs on falling edges and never writes during reset. It loads known segment values through the write port before it relies on them, so every expected address comes from values the bench wrote itself.

// File: rtl/seg_pkg.sv
package seg_pkg;
   localparam int NSEG = 4;
   localparam int SIDX_W = $clog2(NSEG);

   // segment register codes, shared by the override field and the write port
   localparam logic [1:0] SEG_CODE  = 2'd0;
   localparam logic [1:0] SEG_DATA  = 2'd1;
   localparam logic [1:0] SEG_STACK = 2'd2;
   localparam logic [1:0] SEG_EXTRA = 2'd3;

   // access kinds; 5..7 fall back to general data
   localparam logic [2:0] ACC_FETCH = 3'd0;
   localparam logic [2:0] ACC_STACK = 3'd1;
   localparam logic [2:0] ACC_DATA  = 3'd2;
   localparam logic [2:0] ACC_SRC   = 3'd3;
   localparam logic [2:0] ACC_DST   = 3'd4;
endpackage

// File: rtl/seg_bank.sv
module seg_bank
   import seg_pkg::*;
#(
   parameter int SEG_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [SIDX_W-1:0] wsel,
   input  logic [SEG_W-1:0]  wdata,
   output logic [SEG_W-1:0]  seg_q [NSEG]
);
   genvar g;
   generate
      for (g = 0; g < NSEG; g++) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst)
               seg_q[g] <= '0;
            else if (we && (wsel == SIDX_W'(g)))
               seg_q[g] <= wdata;
         end
      end
   endgenerate
endmodule

// File: rtl/seg_policy.sv
module seg_policy
   import seg_pkg::*;
#(
   parameter bit SRC_OVR_OK = 1'b1
) (
   input  logic [2:0]        kind,
   input  logic              ovr_req,
   input  logic [SIDX_W-1:0] ovr_seg,
   output logic [SIDX_W-1:0] pick,
   output logic              refused
);
   logic src_may;

   generate
      if (SRC_OVR_OK) begin : g_src_open
         assign src_may = 1'b1;
      end else begin : g_src_locked
         assign src_may = 1'b0;
      end
   endgenerate

   always_comb begin
      pick    = SEG_DATA;
      refused = 1'b0;
      case (kind)
         ACC_FETCH: begin
            pick    = SEG_CODE;
            refused = ovr_req;
         end
         ACC_STACK: begin
            pick    = SEG_STACK;
            refused = ovr_req;
         end
         ACC_DST: begin
            pick    = SEG_EXTRA;
            refused = ovr_req;
         end
         ACC_SRC: begin
            if (ovr_req && src_may) pick = ovr_seg;
            refused = ovr_req && !src_may;
         end
         default: begin
            if (ovr_req) pick = ovr_seg;
         end
      endcase
   end
endmodule

// File: rtl/seg_sum.sv
module seg_sum #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = SEG_W + SHIFT
) (
   input  logic [SEG_W-1:0]  seg,
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] base;

   assign base = {seg, {SHIFT{1'b0}}};
   // carry beyond the top address bit is discarded
   assign addr = base + ADDR_W'(off);
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
   import seg_pkg::*;
#(
   parameter int SEG_W      = 16,
   parameter int OFF_W      = 16,
   parameter int SHIFT      = 4,
   parameter bit SRC_OVR_OK = 1'b1,
   localparam int ADDR_W    = SEG_W + SHIFT
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [2:0]        acc_kind,
   input  logic [OFF_W-1:0]  acc_off,
   input  logic              ovr_req,
   input  logic [1:0]        ovr_seg,
   input  logic              seg_we,
   input  logic [1:0]        seg_wsel,
   input  logic [SEG_W-1:0]  seg_wdata,
   output logic [ADDR_W-1:0] phys_addr,
   output logic              ovr_fault
);
   generate
      if (SHIFT < 1) begin : g_bad_shift
         $error("seg_addr_gen: SHIFT must be at least 1");
      end
      if (OFF_W > ADDR_W) begin : g_bad_off
         $error("seg_addr_gen: offset wider than address");
      end
   endgenerate

   logic [SEG_W-1:0]  segs [NSEG];
   logic [SIDX_W-1:0] pick;
   logic              refused;
   logic [ADDR_W-1:0] addr_d;

   seg_bank #(.SEG_W(SEG_W)) u_bank (
      .clk   (clk),
      .rst   (rst),
      .we    (seg_we),
      .wsel  (seg_wsel),
      .wdata (seg_wdata),
      .seg_q (segs)
   );

   seg_policy #(.SRC_OVR_OK(SRC_OVR_OK)) u_policy (
      .kind    (acc_kind),
      .ovr_req (ovr_req),
      .ovr_seg (ovr_seg),
      .pick    (pick),
      .refused (refused)
   );

   seg_sum #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_sum (
      .seg  (segs[pick]),
      .off  (acc_off),
      .addr (addr_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phys_addr <= '0;
         ovr_fault <= 1'b0;
      end else begin
         phys_addr <= addr_d;
         ovr_fault <= refused;
      end
   end
endmodule

// File: rtl/seg_addr_gen_chk.sv
module seg_addr_gen_chk #(
   parameter int SEG_W  = 16,
   parameter int OFF_W  = 16,
   parameter int ADDR_W = 20
) (
   input logic              clk,
   input logic              rst,
   input logic [2:0]        acc_kind,
   input logic [OFF_W-1:0]  acc_off,
   input logic              ovr_req,
   input logic [1:0]        ovr_seg,
   input logic              seg_we,
   input logic [1:0]        seg_wsel,
   input logic [SEG_W-1:0]  seg_wdata,
   input logic [ADDR_W-1:0] phys_addr,
   input logic              ovr_fault
);
   logic [SEG_W-1:0] shadow [4];
   logic [1:0]       want_idx;
   logic             locked;

   assign locked = (acc_kind == 3'd0) || (acc_kind == 3'd1) || (acc_kind == 3'd4);

   always_comb begin
      if (acc_kind == 3'd0)      want_idx = 2'd0;
      else if (acc_kind == 3'd1) want_idx = 2'd2;
      else if (acc_kind == 3'd4) want_idx = 2'd3;
      else if (ovr_req)          want_idx = ovr_seg;
      else                       want_idx = 2'd1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 4; i++) shadow[i] <= '0;
      end else if (seg_we) begin
         shadow[seg_wsel] <= seg_wdata;
      end
   end

   // R1: outputs are quiet in the first cycle after reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (phys_addr == '0 && !ovr_fault));

   // R2 and R3: registered address matches the shadowed segment plus offset, wrapped
   p_addr_sum_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (phys_addr == ADDR_W'({$past(shadow[want_idx]), 4'h0} + ADDR_W'($past(acc_off)))));

   // R11: a refused override pulses the fault flag
   p_refused_flag_r11: assert property (@(posedge clk) disable iff (rst)
      (locked && ovr_req) |=> ovr_fault);

   // R12: no fault without an override request
   p_no_req_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      !ovr_req |=> !ovr_fault);

   // R6: overridable kinds never raise the fault flag
   p_open_quiet_r6: assert property (@(posedge clk) disable iff (rst)
      !locked |=> !ovr_fault);
endmodule

bind seg_addr_gen seg_addr_gen_chk #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .acc_kind  (acc_kind),
   .acc_off   (acc_off),
   .ovr_req   (ovr_req),
   .ovr_seg   (ovr_seg),
   .seg_we    (seg_we),
   .seg_wsel  (seg_wsel),
   .seg_wdata (seg_wdata),
   .phys_addr (phys_addr),
   .ovr_fault (ovr_fault)
);

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;
   typedef struct {
      logic [19:0] addr;
      logic        flt;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [2:0]  acc_kind = '0;
   logic [15:0] acc_off = '0;
   logic        ovr_req = 1'b0;
   logic [1:0]  ovr_seg = '0;
   logic        seg_we = 1'b0;
   logic [1:0]  seg_wsel = '0;
   logic [15:0] seg_wdata = '0;
   logic [19:0] phys_addr;
   logic        ovr_fault;

   int n_chk = 0;
   int n_bad = 0;
   exp_t sb [$];
   logic [15:0] mdl [4];

   always #4 clk = ~clk;

   seg_addr_gen u_dut (
      .clk(clk), .rst(rst), .acc_kind(acc_kind), .acc_off(acc_off),
      .ovr_req(ovr_req), .ovr_seg(ovr_seg), .seg_we(seg_we),
      .seg_wsel(seg_wsel), .seg_wdata(seg_wdata),
      .phys_addr(phys_addr), .ovr_fault(ovr_fault)
   );

   // drive one access (plus optional write) and push its expected result
   task automatic drive(input logic [2:0] k, input logic [15:0] off,
                        input logic oreq, input logic [1:0] oseg,
                        input logic we, input logic [1:0] ws, input logic [15:0] wd,
                        input string tag);
      exp_t e;
      logic [1:0] idx;
      @(negedge clk);
      acc_kind = k; acc_off = off; ovr_req = oreq; ovr_seg = oseg;
      seg_we = we; seg_wsel = ws; seg_wdata = wd;
      case (k)
         3'd0: idx = 2'd0;
         3'd1: idx = 2'd2;
         3'd4: idx = 2'd3;
         default: idx = oreq ? oseg : 2'd1;
      endcase
      e.addr = {mdl[idx], 4'h0} + {4'h0, off};
      e.flt  = oreq && (k == 3'd0 || k == 3'd1 || k == 3'd4);
      e.tag  = tag;
      sb.push_back(e);
      if (we) mdl[ws] = wd;
   endtask

   task automatic wr(input logic [1:0] ws, input logic [15:0] wd);
      drive(3'd2, 16'h0000, 1'b0, 2'd0, 1'b1, ws, wd, "R10");
   endtask

   // monitor: compare each result in the cycle it appears
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if (phys_addr !== e.addr || ovr_fault !== e.flt) begin
               n_bad++;
               $display("FAIL %s: addr=%05h flt=%0b expected addr=%05h flt=%0b",
                        e.tag, phys_addr, ovr_fault, e.addr, e.flt);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) mdl[i] = 16'h0000;
      repeat (3) @(negedge clk);
      // R1: outputs held at zero during reset
      n_chk++;
      if (phys_addr !== 20'h0 || ovr_fault !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: addr=%05h flt=%0b expected addr=00000 flt=0", phys_addr, ovr_fault);
      end
      rst = 1'b0;
      // R1: segments reset to zero, so the address equals the offset
      drive(3'd0, 16'hABCD, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R1");
      drive(3'd2, 16'h1357, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R1");
      // R10: write the segment registers
      wr(2'd0, 16'h1234);
      wr(2'd1, 16'h7FA2);
      wr(2'd2, 16'h0105);
      wr(2'd3, 16'hB3FF);
      // R2 and R4: fetch from the code segment
      drive(3'd0, 16'h0022, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R2");
      // R6: data default, then each override code
      drive(3'd2, 16'h438E, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R6");
      drive(3'd2, 16'h0010, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0, "R6");
      drive(3'd2, 16'h0010, 1'b1, 2'd1, 1'b0, 2'd0, 16'h0, "R6");
      drive(3'd2, 16'h0010, 1'b1, 2'd2, 1'b0, 2'd0, 16'h0, "R6");
      drive(3'd2, 16'h0010, 1'b1, 2'd3, 1'b0, 2'd0, 16'h0, "R6");
      // R3: upper end of a segment and full wrap
      drive(3'd2, 16'hFFFF, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R3");
      wr(2'd1, 16'hFFFF);
      drive(3'd2, 16'h0010, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R3");
      drive(3'd2, 16'hFFFF, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R3");
      // R5: stack
      drive(3'd1, 16'h0008, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R5");
      // R7: string source, default and override
      drive(3'd3, 16'h0200, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R7");
      drive(3'd3, 16'h0200, 1'b1, 2'd3, 1'b0, 2'd0, 16'h0, "R7");
      // R8: string destination
      drive(3'd4, 16'h0005, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R8");
      // R11: refused overrides on fetch, stack and destination
      drive(3'd0, 16'h0100, 1'b1, 2'd1, 1'b0, 2'd0, 16'h0, "R11");
      drive(3'd1, 16'h0100, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0, "R11");
      drive(3'd4, 16'h0100, 1'b1, 2'd2, 1'b0, 2'd0, 16'h0, "R11");
      // R12: flag drops right after a refused override
      drive(3'd4, 16'h0100, 1'b0, 2'd2, 1'b0, 2'd0, 16'h0, "R12");
      // R9: kinds 5..7 act as general data
      drive(3'd5, 16'h0040, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R9");
      drive(3'd6, 16'h0040, 1'b1, 2'd2, 1'b0, 2'd0, 16'h0, "R9");
      drive(3'd7, 16'h0040, 1'b1, 2'd0, 1'b0, 2'd0, 16'h0, "R9");
      // R10: same-cycle write is not seen, next access sees it
      drive(3'd0, 16'h0001, 1'b0, 2'd0, 1'b1, 2'd0, 16'h4000, "R10");
      drive(3'd0, 16'h0001, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "R10");
      // mixed traffic
      for (int i = 0; i < 300; i++) begin
         logic [31:0] r;
         r = $urandom();
         drive(r[2:0], r[18:3], r[19], r[21:20], r[22], r[24:23],
               {r[31:25], r[8:0]}, "R2");
      end
      @(negedge clk);
      @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule